// File: doc/BRIEF.md
# I2C Transfer Length Sequencer

This block decides what an I2C master does once it has moved a programmed number of bytes. Software loads an 8-bit segment length. A byte-level shifter reports each finished byte with a one-cycle pulse, and each pulse counts the remaining length down. When the count runs out, the sequencer does one of three things. It asks the bit engine for a STOP. Or it raises a transfer-complete flag and holds SCL low until software acts. Or, when reload is on, it stalls the same way so that software can load the next segment without a STOP.

While the transfer runs, the block also tells the shifter two things. The first is whether to NACK the byte it is receiving, which is the final byte of the last segment in receive mode. The second is whether the current byte is a trailing PEC byte. Software sets the PEC request by writing a pulse. Hardware clears it when the PEC byte completes, when a STOP is observed, or when the peripheral is disabled. Timing on SCL and SDA, address matching and CRC arithmetic belong to other blocks.

Top module: `i2c_len_seq`

## Requirements
- R1: While `rst_n` is low, or after any clock edge with `enable` low, `bytes_left` is 0 and `tc_flag`, `scl_hold`, `stop_req` and `pec_req` are all 0.
- R2: A pulse on `cnt_wr` with `start_pending` low loads `cnt_wdata` into `bytes_left` at the next edge. With `start_pending` high the write is dropped and `bytes_left` keeps its value.
- R3: A `byte_done` pulse is accepted when `bytes_left` is nonzero, `scl_hold` is 0 and no count write is loaded in the same cycle. An accepted pulse lowers `bytes_left` by one. Any other pulse changes nothing, so the count never wraps below 0.
- R4: With `reload_en`=1, the accepted byte that takes `bytes_left` from 1 to 0 sets `tc_flag` and `scl_hold` at the next edge, and `stop_req` stays 0.
- R5: With `reload_en`=0 and `auto_end`=0, that same final byte sets `tc_flag` and `scl_hold` at the next edge, with no STOP request.
- R6: With `reload_en`=0 and `auto_end`=1, that final byte makes `stop_req` high for exactly one cycle after the next edge, and `tc_flag` and `scl_hold` stay 0.
- R7: `auto_end` has no effect while `reload_en`=1. The end of the count stalls as in R4.
- R8: A loaded count write clears `tc_flag` and `scl_hold` at the next edge, which releases SCL.
- R9: `nack_out` is high in the same cycle whenever `rx_mode`=1, `reload_en`=0 and `bytes_left`=1. Otherwise it is low.
- R10: A `pec_set` pulse sets `pec_req`. `pec_req` is cleared by `stop_seen`, by an accepted byte while `pec_send` is high, or by `enable` low. A clear wins over a set in the same cycle.
- R11: `pec_send` is high exactly when `pec_req`=1, `reload_en`=0 and `bytes_left`=1, so the PEC byte is the last byte of the count. While reload is on, `pec_send` stays 0 and the end of a segment leaves `pec_req` set.
- R12: While `scl_hold` is 1, `byte_done` pulses leave `bytes_left` and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low clears the state synchronously |
| start_pending | input | 1 | A START request is outstanding; count writes are locked |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | CW | Count value to load |
| reload_en | input | 1 | Stall for a new count at the end of each segment |
| auto_end | input | 1 | 1: STOP at end of count; 0: stall for software |
| rx_mode | input | 1 | Master is receiving |
| pec_set | input | 1 | Software pulse that requests a PEC byte |
| stop_seen | input | 1 | STOP observed on the bus |
| byte_done | input | 1 | One byte finished on the bus |
| bytes_left | output | CW | Remaining bytes in the segment |
| tc_flag | output | 1 | Transfer-complete flag |
| scl_hold | output | 1 | Hold SCL low |
| stop_req | output | 1 | One-cycle STOP request |
| nack_out | output | 1 | NACK the byte being received |
| pec_send | output | 1 | Current byte is the PEC byte |
| pec_req | output | 1 | PEC byte requested |

## Verification
The hardest case to reach from the ports is the one where several events meet at the final byte of a count. This happens when a count write, a PEC set or clear, and a mode change fall in the same cycle as that last `byte_done`, or while SCL is held. Directed sequences walk each end mode to its stall or STOP and release the stall with a write. A seeded random phase then keeps counts small (0 to 5), so segment ends come often. In that phase `byte_done` fires every other cycle on average and writes, PEC pulses and mode flips are scattered, so these collisions occur many times. A cycle-level model in the bench checks every output on every cycle.

// File: rtl/i2c_len_seq.sv
module i2c_len_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          start_pending,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          reload_en,
  input  logic          auto_end,
  input  logic          rx_mode,
  input  logic          pec_set,
  input  logic          stop_seen,
  input  logic          byte_done,
  output logic [CW-1:0] bytes_left,
  output logic          tc_flag,
  output logic          scl_hold,
  output logic          stop_req,
  output logic          nack_out,
  output logic          pec_send,
  output logic          pec_req
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] left_q;
  logic tc_q, hold_q, stop_q, pec_q;

  wire load     = cnt_wr && !start_pending;
  wire last     = (left_q == ONE);
  wire accept   = byte_done && !load && (left_q != ZERO) && !hold_q;
  wire seg_end  = accept && last;
  wire stall    = reload_en || !auto_end;
  wire final_sg = !reload_en && last;

  assign bytes_left = left_q;
  assign tc_flag    = tc_q;
  assign scl_hold   = hold_q;
  assign stop_req   = stop_q;
  assign pec_req    = pec_q;
  assign nack_out   = rx_mode && final_sg;
  assign pec_send   = pec_q && final_sg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      tc_q   <= 1'b0;
      hold_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (!enable) begin
      left_q <= '0;
      tc_q   <= 1'b0;
      hold_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      stop_q <= seg_end && !stall;
      if (load) begin
        left_q <= cnt_wdata;
        tc_q   <= 1'b0;
        hold_q <= 1'b0;
      end else if (accept) begin
        left_q <= left_q - ONE;
        if (seg_end && stall) begin
          tc_q   <= 1'b1;
          hold_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      pec_q <= 1'b0;
    else if (!enable || stop_seen || (accept && pec_send)) pec_q <= 1'b0;
    else if (pec_set)                                pec_q <= 1'b1;
  end

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && byte_done && !load && left_q == ZERO) |=> (bytes_left == ZERO));

  a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt_wr && start_pending && !byte_done) |=> $stable(bytes_left));

  a_r6_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  a_r6_stop_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (!tc_flag && !scl_hold));

  a_r12_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && scl_hold && !load) |=> ($stable(bytes_left) && scl_hold));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && load) |=> (!tc_flag && !scl_hold));

  a_r1_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (bytes_left == ZERO && !tc_flag && !scl_hold && !pec_req && !stop_req));

  a_r11_pec_last: assert property (@(posedge clk) disable iff (!rst_n)
    pec_send |-> (bytes_left == ONE && !reload_en));
endmodule

// File: tb/i2c_len_seq_tb_top.sv
module i2c_len_seq_tb_top;
  localparam int CW = 8;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, start_pending = 0, cnt_wr = 0, reload_en = 0, auto_end = 0;
  logic rx_mode = 0, pec_set = 0, stop_seen = 0, byte_done = 0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [CW-1:0] bytes_left;
  logic tc_flag, scl_hold, stop_req, nack_out, pec_send, pec_req;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [CW-1:0] m_left = '0;
  logic m_tc = 0, m_hold = 0, m_stop = 0, m_pec = 0;

  always #(TCLK/2) clk = ~clk;

  i2c_len_seq #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_pending(start_pending),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .reload_en(reload_en),
    .auto_end(auto_end), .rx_mode(rx_mode), .pec_set(pec_set),
    .stop_seen(stop_seen), .byte_done(byte_done), .bytes_left(bytes_left),
    .tc_flag(tc_flag), .scl_hold(scl_hold), .stop_req(stop_req),
    .nack_out(nack_out), .pec_send(pec_send), .pec_req(pec_req));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_nack();
    return rx_mode && !reload_en && (m_left == CW'(1));
  endfunction

  function automatic logic exp_pecs();
    return m_pec && !reload_en && (m_left == CW'(1));
  endfunction

  task automatic cmp_regs();
    chk("R3 bytes_left", int'(bytes_left), int'(m_left));
    chk("R5 tc_flag", int'(tc_flag), int'(m_tc));
    chk("R8 scl_hold", int'(scl_hold), int'(m_hold));
    chk("R6 stop_req", int'(stop_req), int'(m_stop));
    chk("R10 pec_req", int'(pec_req), int'(m_pec));
  endtask

  // drive at negedge, check comb at +1, advance model at posedge, check regs at negedge
  task automatic cyc();
    logic ld, acc, lst, ps;
    #1;
    chk("R9 nack_out", int'(nack_out), int'(exp_nack()));
    chk("R11 pec_send", int'(pec_send), int'(exp_pecs()));
    ps  = exp_pecs();
    ld  = cnt_wr && !start_pending;
    lst = (m_left == CW'(1));
    acc = byte_done && !ld && (m_left != '0) && !m_hold;
    @(posedge clk);
    if (!enable) begin
      m_left = '0; m_tc = 0; m_hold = 0; m_stop = 0; m_pec = 0;
    end else begin
      m_stop = acc && lst && !reload_en && auto_end;
      if (ld) begin
        m_left = cnt_wdata; m_tc = 0; m_hold = 0;
      end else if (acc) begin
        m_left = m_left - 1'b1;
        if (lst && (reload_en || !auto_end)) begin m_tc = 1; m_hold = 1; end
      end
      if (stop_seen || (acc && ps)) m_pec = 0;
      else if (pec_set) m_pec = 1;
    end
    @(negedge clk);
    cmp_regs();
  endtask

  task automatic quiet();
    cnt_wr = 0; pec_set = 0; stop_seen = 0; byte_done = 0;
  endtask

  task automatic wr(input int v);
    quiet(); cnt_wr = 1; cnt_wdata = CW'(v); cyc(); quiet();
  endtask

  task automatic bd();
    quiet(); byte_done = 1; cyc(); quiet();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset bytes_left", int'(bytes_left), 0);
    chk("R1 reset flags", int'({tc_flag, scl_hold, stop_req, pec_req}), 0);
    rst_n = 1; enable = 1;
    @(negedge clk);

    start_pending = 1; wr(5);
    chk("R2 locked write", int'(bytes_left), 0);
    start_pending = 0; wr(3);
    chk("R2 loaded write", int'(bytes_left), 3);

    reload_en = 1; auto_end = 0;
    bd(); bd(); bd();
    chk("R4 reload tc", int'(tc_flag), 1);
    chk("R4 reload hold", int'(scl_hold), 1);
    chk("R4 reload no stop", int'(stop_req), 0);
    bd();
    chk("R12 held count", int'(bytes_left), 0);
    chk("R12 held flag", int'(tc_flag), 1);
    wr(2);
    chk("R8 release", int'({tc_flag, scl_hold}), 0);
    chk("R8 reload count", int'(bytes_left), 2);

    auto_end = 1; bd(); bd();
    chk("R7 auto ignored hold", int'(scl_hold), 1);
    chk("R7 auto ignored stop", int'(stop_req), 0);

    reload_en = 0; wr(1); bd();
    chk("R6 stop pulse", int'(stop_req), 1);
    chk("R6 no flag", int'(tc_flag), 0);
    quiet(); cyc();
    chk("R6 stop single", int'(stop_req), 0);

    auto_end = 0; wr(1); bd();
    chk("R5 soft end tc", int'({tc_flag, scl_hold}), 3);
    chk("R5 soft end no stop", int'(stop_req), 0);

    rx_mode = 1; auto_end = 1;
    quiet(); pec_set = 1; cyc(); quiet();
    chk("R10 pec set", int'(pec_req), 1);
    wr(2); bd();
    #1;
    chk("R11 pec byte", int'(pec_send), 1);
    chk("R9 nack last", int'(nack_out), 1);
    bd();
    chk("R10 pec cleared", int'(pec_req), 0);

    reload_en = 1;
    quiet(); pec_set = 1; cyc(); quiet();
    wr(1);
    #1;
    chk("R11 pec off in reload", int'(pec_send), 0);
    chk("R9 nack off in reload", int'(nack_out), 0);
    bd();
    chk("R11 pec kept", int'(pec_req), 1);

    enable = 0; quiet(); cyc();
    chk("R1 disable clears", int'({bytes_left, tc_flag, scl_hold, pec_req}), 0);
    enable = 1;

    for (int i = 0; i < 4000; i++) begin
      enable        = ($urandom_range(99) >= 2);
      start_pending = ($urandom_range(99) < 25);
      cnt_wr        = ($urandom_range(99) < 12);
      cnt_wdata     = CW'($urandom_range(5));
      byte_done     = ($urandom_range(1) == 1);
      pec_set       = ($urandom_range(99) < 8);
      stop_seen     = ($urandom_range(99) < 3);
      if ($urandom_range(99) < 5) reload_en = ~reload_en;
      if ($urandom_range(99) < 5) auto_end  = ~auto_end;
      if ($urandom_range(99) < 5) rx_mode   = ~rx_mode;
      cyc();
    end
    finish_run();
  end
endmodule